// File: doc/BRIEF.md
# Prioritised Interrupt Aggregator with Critical Vectoring

The block gathers a parameterised number of interrupt sources (32 by default) into two processor-facing request lines. One line is for ordinary interrupts and one is for critical interrupts. Each source is set as edge-captured or level-following by its own trigger bit. Captured events are held in a pending-status word. Software programs an enable mask, and a critical-class mask sorts the enabled pending sources between the two lines.

Software reaches the block through a word-wide register port with a combinational read path and single-cycle writes. For critical requests an optional vector unit forms a handler address. The address is a programmable base plus 512 times the position of the winning pending critical source. The search runs upward from bit 0 or downward from the top bit, as software selects. Status bits are stored in reversed order: source n sits in status bit NUM_SRC-1-n.

Top module: `irq_hub`

## Requirements
- R1: After reset, every register offset reads 0, and both `irq_o` and `crit_o` are low.
- R2: Source input n is recorded in status bit NUM_SRC-1-n, so source 0 appears in the most significant bit.
- R3: A source whose trigger bit (offset 5) is 1 sets its status bit on a 0-to-1 input transition. The bit stays set after the input falls.
- R4: A source whose trigger bit is 0 has a status bit that takes the input value on every input change. A write-one-to-clear leaves the bit set while the input is still high.
- R5: Writing offset 0 clears exactly the status bits written as 1, apart from the level sources that are still asserted.
- R6: Writing offset 1 ORs the data into status, and reading offset 1 returns status.
- R7: Offset 6 reads status AND enable (offset 2). Writes to offsets 6 and 7 change nothing.
- R8: `irq_o` is high exactly when status AND enable AND NOT critical-select (offset 3) is nonzero.
- R9: `crit_o` is high exactly when status AND enable AND critical-select is nonzero.
- R10: The vector configuration (offset 8) always stores bit 1 as 0. When its bit 0 is 0, the vector (offset 7) is the configuration with bits 1:0 cleared, plus 512 times the index of the lowest pending critical bit.
- R11: When configuration bit 0 is 1, the vector is the cleared base plus 512 times (NUM_SRC-1 minus the index of the highest pending critical bit).
- R12: The vector reads 0 whenever no enabled critical bit is pending.
- R13: The polarity register (offset 4) is stored and read back with no effect on status or outputs. Offsets 9 to 15 read 0, and writes to them have no effect.
- R14: With the vector option disabled, offsets 7 and 8 read 0 while everything else behaves as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt source inputs, synchronous to clk |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | NUM_SRC | Register write data |
| bus_rdata | output | NUM_SRC | Combinational read data for bus_addr |
| irq_o | output | 1 | Normal interrupt request |
| crit_o | output | 1 | Critical interrupt request |

## Verification
The assertions assume that source inputs are already synchronous to the clock and that a write strobe lasts one cycle. They also assume that the register write and a source transition resolve in a fixed order, with the input event overriding the software effect on the same bit. The stimulus changes inputs and bus signals only on the falling edge. It keeps every write to a single strobe cycle. A behavioural model tracks each cycle, so random interleavings of source toggles and writes are legal by construction. A second instance with vectoring disabled runs on the same stimulus.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int OFS_W = 4;
  localparam int VEC_STRIDE_LOG2 = 9;

  typedef enum logic [OFS_W-1:0] {
    OFS_STAT   = 4'd0,
    OFS_SET    = 4'd1,
    OFS_EN     = 4'd2,
    OFS_CRIT   = 4'd3,
    OFS_POL    = 4'd4,
    OFS_TRIG   = 4'd5,
    OFS_MASKED = 4'd6,
    OFS_VEC    = 4'd7,
    OFS_VCFG   = 4'd8
  } ofs_e;
endpackage

// File: rtl/irq_capture.sv
`timescale 1ns/1ps
module irq_capture #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] trig_i,
  input  logic               clr_en_i,
  input  logic [NUM_SRC-1:0] clr_mask_i,
  input  logic               set_en_i,
  input  logic [NUM_SRC-1:0] set_mask_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic [NUM_SRC-1:0] level_o,
  output logic [NUM_SRC-1:0] raw_o,
  output logic [NUM_SRC-1:0] prev_o
);
  logic [NUM_SRC-1:0] raw;
  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] status_q, status_d;
  logic [NUM_SRC-1:0] level_q, level_d;
  logic [NUM_SRC-1:0] sw_st, lvl_chg, edge_rise;
  logic               status_en;

  // source n maps to status bit NUM_SRC-1-n
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_rev
    assign raw[NUM_SRC-1-g] = src_i[g];
  end

  always_comb begin
    sw_st = status_q;
    if (clr_en_i) begin
      sw_st = (status_q & ~clr_mask_i) | level_q;
    end else if (set_en_i) begin
      sw_st = status_q | set_mask_i;
    end
    lvl_chg   = (raw ^ prev_q) & ~trig_i;
    edge_rise = raw & ~prev_q & trig_i;
    status_d  = ((sw_st | edge_rise) & ~lvl_chg) | (raw & lvl_chg);
    level_d   = (level_q & ~lvl_chg) | (raw & lvl_chg);
    status_en = clr_en_i | set_en_i | (|(raw ^ prev_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= raw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      level_q  <= '0;
    end else if (status_en) begin
      status_q <= status_d;
      level_q  <= level_d;
    end
  end

  assign status_o = status_q;
  assign level_o  = level_q;
  assign raw_o    = raw;
  assign prev_o   = prev_q;
endmodule

// File: rtl/irq_regs.sv
`timescale 1ns/1ps
module irq_regs
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter bit HAS_VEC = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [OFS_W-1:0]   addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] crit_o,
  output logic [NUM_SRC-1:0] pol_o,
  output logic [NUM_SRC-1:0] trig_o,
  output logic [NUM_SRC-1:0] vcfg_o
);
  logic [NUM_SRC-1:0] en_q, crit_q, pol_q, trig_q;
  logic en_we, crit_we, pol_we, trig_we, vcfg_we;

  always_comb begin
    en_we   = wr_en_i && (addr_i == OFS_EN);
    crit_we = wr_en_i && (addr_i == OFS_CRIT);
    pol_we  = wr_en_i && (addr_i == OFS_POL);
    trig_we = wr_en_i && (addr_i == OFS_TRIG);
    vcfg_we = wr_en_i && (addr_i == OFS_VCFG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      crit_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
    end else begin
      if (en_we)   en_q   <= wdata_i;
      if (crit_we) crit_q <= wdata_i;
      if (pol_we)  pol_q  <= wdata_i;
      if (trig_we) trig_q <= wdata_i;
    end
  end

  if (HAS_VEC) begin : g_vcfg
    logic [NUM_SRC-1:0] vcfg_q, vcfg_d;
    always_comb begin
      vcfg_d    = wdata_i;
      vcfg_d[1] = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vcfg_q <= '0;
      end else if (vcfg_we) begin
        vcfg_q <= vcfg_d;
      end
    end
    assign vcfg_o = vcfg_q;
  end else begin : g_no_vcfg
    logic unused_we;
    assign unused_we = vcfg_we;
    assign vcfg_o    = '0;
  end

  assign en_o   = en_q;
  assign crit_o = crit_q;
  assign pol_o  = pol_q;
  assign trig_o = trig_q;
endmodule

// File: rtl/irq_vector.sv
`timescale 1ns/1ps
module irq_vector
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0] pend_crit_i,
  input  logic [NUM_SRC-1:0] vcfg_i,
  output logic [NUM_SRC-1:0] vec_o
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [IDX_W-1:0]   up_pos, down_pos, pos;
  logic [NUM_SRC-1:0] base, offset;

  always_comb begin
    up_pos   = '0;
    down_pos = '0;
    // later iterations overwrite: lowest index wins here
    for (int i = NUM_SRC-1; i >= 0; i--) begin
      if (pend_crit_i[i]) up_pos = IDX_W'(i);
    end
    // highest index wins, measured from the top bit
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_crit_i[i]) down_pos = IDX_W'(NUM_SRC-1-i);
    end
    pos       = vcfg_i[0] ? down_pos : up_pos;
    base      = vcfg_i;
    base[1:0] = 2'b00;
    offset    = NUM_SRC'(pos) << VEC_STRIDE_LOG2;
    vec_o     = (|pend_crit_i) ? (base + offset) : '0;
  end
endmodule

// File: rtl/irq_hub.sv
`timescale 1ns/1ps
module irq_hub
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter bit HAS_VEC = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_we,
  input  logic [3:0]         bus_addr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic               irq_o,
  output logic               crit_o
);
  logic [NUM_SRC-1:0] status_w, level_w, raw_w, prev_w;
  logic [NUM_SRC-1:0] en_w, critsel_w, pol_w, trig_w, vcfg_w, vec_w;
  logic [NUM_SRC-1:0] masked_w, pend_norm_w, pend_crit_w;
  logic               clr_en, set_en;

  assign clr_en = bus_we && (bus_addr == OFS_STAT);
  assign set_en = bus_we && (bus_addr == OFS_SET);

  irq_capture #(.NUM_SRC(NUM_SRC)) cap_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .trig_i(trig_w),
    .clr_en_i(clr_en), .clr_mask_i(bus_wdata),
    .set_en_i(set_en), .set_mask_i(bus_wdata),
    .status_o(status_w), .level_o(level_w), .raw_o(raw_w), .prev_o(prev_w)
  );

  irq_regs #(.NUM_SRC(NUM_SRC), .HAS_VEC(HAS_VEC)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(bus_we), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .en_o(en_w), .crit_o(critsel_w), .pol_o(pol_w),
    .trig_o(trig_w), .vcfg_o(vcfg_w)
  );

  assign masked_w    = status_w & en_w;
  assign pend_norm_w = masked_w & ~critsel_w;
  assign pend_crit_w = masked_w & critsel_w;

  if (HAS_VEC) begin : g_vec
    irq_vector #(.NUM_SRC(NUM_SRC)) vec_i (
      .pend_crit_i(pend_crit_w), .vcfg_i(vcfg_w), .vec_o(vec_w)
    );
  end else begin : g_no_vec
    assign vec_w = '0;
  end

  assign irq_o  = |pend_norm_w;
  assign crit_o = |pend_crit_w;

  always_comb begin
    unique case (bus_addr)
      OFS_STAT, OFS_SET: bus_rdata = status_w;
      OFS_EN:            bus_rdata = en_w;
      OFS_CRIT:          bus_rdata = critsel_w;
      OFS_POL:           bus_rdata = pol_w;
      OFS_TRIG:          bus_rdata = trig_w;
      OFS_MASKED:        bus_rdata = masked_w;
      OFS_VEC:           bus_rdata = vec_w;
      OFS_VCFG:          bus_rdata = vcfg_w;
      default:           bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_hub_chk.sv
`timescale 1ns/1ps
module irq_hub_chk #(
  parameter int NUM_SRC = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_we,
  input logic [3:0]         bus_addr,
  input logic [NUM_SRC-1:0] bus_wdata,
  input logic [NUM_SRC-1:0] status,
  input logic [NUM_SRC-1:0] level,
  input logic [NUM_SRC-1:0] raw,
  input logic [NUM_SRC-1:0] prev,
  input logic [NUM_SRC-1:0] trig,
  input logic [NUM_SRC-1:0] en,
  input logic [NUM_SRC-1:0] vec,
  input logic               irq_o,
  input logic               crit_o
);
  logic [NUM_SRC-1:0] clr_word, rise_edge, lvl_move;
  logic               clr_wr, set_wr;

  always_comb begin
    clr_wr    = bus_we && (bus_addr == 4'd0);
    set_wr    = bus_we && (bus_addr == 4'd1);
    clr_word  = clr_wr ? bus_wdata : '0;
    rise_edge = raw & ~prev & trig;
    lvl_move  = (raw ^ prev) & ~trig;
  end

  // R3: a set edge bit survives unless software clears it
  p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status & trig & ~clr_word)) |=> (($past(status & trig & ~clr_word) & ~status) == '0));

  // R3: a rising edge source is pending one cycle later
  p_rise_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_edge) |=> (($past(rise_edge) & ~status) == '0));

  // R4: still-asserted level sources survive a clear write
  p_level_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (($past(level & ~(raw ^ prev)) & ~status) == '0));

  // R6: set write lands unless a level source falls in the same cycle
  p_set_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> (($past(bus_wdata & ~lvl_move) & ~status) == '0));

  // R8: nothing enabled means no request
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> (!irq_o && !crit_o));

  // R12: no critical request means zero vector
  p_vec_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !crit_o |-> (vec == '0));
endmodule

bind irq_hub irq_hub_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .status(status_w), .level(level_w), .raw(raw_w),
  .prev(prev_w), .trig(trig_w), .en(en_w), .vec(vec_w),
  .irq_o(irq_o), .crit_o(crit_o)
);

// File: tb/irq_hub_tb_top.sv
`timescale 1ns/1ps
module irq_hub_tb_top;
  logic        clk;
  logic        rst_n;
  logic [31:0] src;
  logic        we;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata, nv_rdata;
  logic        irq, crit, nv_irq, nv_crit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] m_st, m_en, m_cr, m_pr, m_tr, m_vc, m_lvl, m_prev;

  irq_hub #(.NUM_SRC(32), .HAS_VEC(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .crit_o(crit)
  );

  irq_hub #(.NUM_SRC(32), .HAS_VEC(1'b0)) dut_nv_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(nv_rdata), .irq_o(nv_irq), .crit_o(nv_crit)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] m_vec();
    logic [31:0] c, base;
    c = m_st & m_en & m_cr;
    base = m_vc & 32'hFFFF_FFFC;
    if (c == 0) return 32'h0;
    if (!m_vc[0]) begin
      for (int i = 0; i < 32; i++) if (c[i]) return base + 32'(i) * 512;
    end else begin
      for (int i = 31; i >= 0; i--) if (c[i]) return base + 32'(31 - i) * 512;
    end
    return 32'h0;
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] a, input bit vec_on);
    case (a)
      4'd0, 4'd1: return m_st;
      4'd2: return m_en;
      4'd3: return m_cr;
      4'd4: return m_pr;
      4'd5: return m_tr;
      4'd6: return m_st & m_en;
      4'd7: return vec_on ? m_vec() : 32'h0;
      4'd8: return vec_on ? m_vc : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_en = 0; m_cr = 0; m_pr = 0; m_tr = 0; m_vc = 0; m_lvl = 0; m_prev = 0;
    end else begin
      logic [31:0] old_tr;
      old_tr = m_tr;
      if (we) begin
        case (addr)
          4'd0: m_st = (m_st & ~wdata) | m_lvl;
          4'd1: m_st = m_st | wdata;
          4'd2: m_en = wdata;
          4'd3: m_cr = wdata;
          4'd4: m_pr = wdata;
          4'd5: m_tr = wdata;
          4'd8: m_vc = wdata & 32'hFFFF_FFFD;
          default: ;
        endcase
      end
      for (int n = 0; n < 32; n++) begin
        int b;
        b = 31 - n;
        if (src[n] != m_prev[b]) begin
          if (old_tr[b]) begin
            if (src[n]) m_st[b] = 1'b1;
          end else begin
            m_st[b]  = src[n];
            m_lvl[b] = src[n];
          end
        end
        m_prev[b] = src[n];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model (R7..R14)
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R8 irq_o", {31'd0, irq}, {31'd0, |(m_st & m_en & ~m_cr)});
      chk("R9 crit_o", {31'd0, crit}, {31'd0, |(m_st & m_en & m_cr)});
      chk("R7 read path", rdata, m_read(addr, 1'b1));
      chk("R14 no-vector read path", nv_rdata, m_read(addr, 1'b0));
      chk("R14 no-vector irq", {30'd0, nv_irq, nv_crit}, {30'd0, irq, crit});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    we = 1'b0; addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic setsrc(input logic [31:0] v);
    @(negedge clk);
    src = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; src = 0; we = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 9; a++) rd("R1 reset register", 4'(a), 32'h0);
    #0 chk("R1 outputs after reset", {30'd0, irq, crit}, 32'h0);

    // R2/R4: level mapping, source 0 in the top bit
    setsrc(32'h0000_0001);
    rd("R2 source 0 in bit 31", 4'd0, 32'h8000_0000);
    setsrc(32'h8000_0001);
    rd("R2 source 31 in bit 0", 4'd0, 32'h8000_0001);
    wr(4'd0, 32'hFFFF_FFFF);
    rd("R4 asserted level bits survive clear", 4'd0, 32'h8000_0001);
    setsrc(32'h0);
    rd("R4 level bits follow falling input", 4'd0, 32'h0);

    // R3: edge sources 0..15
    wr(4'd5, 32'hFFFF_0000);
    setsrc(32'h0000_0008);
    rd("R3 edge sets status", 4'd0, 32'h1000_0000);
    setsrc(32'h0);
    rd("R3 edge bit held after fall", 4'd0, 32'h1000_0000);
    wr(4'd0, 32'h1000_0000);
    rd("R5 clear edge bit", 4'd0, 32'h0);

    // R6/R5
    wr(4'd1, 32'h0000_00F0);
    rd("R6 set read via offset 1", 4'd1, 32'h0000_00F0);
    wr(4'd0, 32'h0000_0030);
    rd("R5 selective clear", 4'd0, 32'h0000_00C0);

    // R7/R8/R9
    wr(4'd2, 32'h0000_00FF);
    rd("R7 masked status", 4'd6, 32'h0000_00C0);
    #0 chk("R8 normal request", {31'd0, irq}, 32'h1);
    wr(4'd6, 32'hFFFF_FFFF);
    rd("R7 masked write ignored", 4'd6, 32'h0000_00C0);
    rd("R7 status untouched", 4'd0, 32'h0000_00C0);
    wr(4'd3, 32'h0000_0040);
    rd("R9 split classes", 4'd3, 32'h0000_0040);
    #0 chk("R9 both requests", {30'd0, irq, crit}, 32'h3);
    wr(4'd3, 32'h0000_00C0);
    rd("R8 all critical", 4'd3, 32'h0000_00C0);
    #0 chk("R8 normal low crit high", {30'd0, irq, crit}, 32'h1);

    // R10/R11 vectoring
    wr(4'd8, 32'h0001_0002);
    rd("R10 config bit1 stored as 0", 4'd8, 32'h0001_0000);
    rd("R10 upward vector", 4'd7, 32'h0001_0C00);
    wr(4'd7, 32'h1234_5678);
    rd("R7 vector write ignored", 4'd7, 32'h0001_0C00);
    wr(4'd8, 32'h0001_0003);
    rd("R11 config readback", 4'd8, 32'h0001_0001);
    rd("R11 downward vector", 4'd7, 32'h0001_3000);
    #0 chk("R14 vector hidden", nv_rdata, 32'h0);
    rd("R14 config hidden", 4'd8, 32'h0001_0001);
    #0 chk("R14 config reads 0", nv_rdata, 32'h0);
    wr(4'd1, 32'h0000_0001);
    wr(4'd2, 32'h0000_00FF);
    wr(4'd3, 32'h0000_00C1);
    rd("R11 bit 31 side", 4'd7, 32'h0001_3000);
    wr(4'd2, 32'h0000_00C1);
    wr(4'd8, 32'h0000_0000);
    rd("R10 lowest bit 0", 4'd7, 32'h0000_0000 + 32'h0);

    // R12
    wr(4'd0, 32'hFFFF_FFFF);
    rd("R12 vector zero when idle", 4'd7, 32'h0);
    #0 chk("R12 crit low", {31'd0, crit}, 32'h0);

    // R13
    wr(4'd4, 32'hA5A5_A5A5);
    rd("R13 polarity readback", 4'd4, 32'hA5A5_A5A5);
    rd("R13 polarity no status effect", 4'd0, 32'h0);
    wr(4'd9, 32'h1234_5678);
    rd("R13 undefined offset reads 0", 4'd9, 32'h0);
    rd("R13 undefined write no effect", 4'd2, 32'h0000_00C1);

    // random interleaving, compared every cycle
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if ($urandom % 6 == 0) src = src ^ (32'h1 << ($urandom % 32));
      addr  = 4'($urandom % 16);
      wdata = $urandom;
      we    = ($urandom % 5 == 0);
    end
    @(negedge clk);
    we = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule